// File: doc/BRIEF.md
# Link Mode Resolver

Once auto-negotiation has finished, this block works out the operating speed and duplex of the MAC and builds the 32-bit station-control word that carries them.

On a start pulse it does the following:

- It masks the link partner's ability word with the local advertisement word.
- It picks the highest-ranked common mode.
- It writes that mode into the speed/duplex field of the current control word. Every other bit of the word passes through unchanged.

The new word appears with a one-cycle write strobe, together with a compact 3-bit mode code. When the MAC is wired for the reduced-pin gigabit interface, two further write pulses go to a clock-delay register after the control write.

The word is built in these steps:

- The field bits (mask 0x0F001C00) are cleared from the current word.
- A speed base value is ORed in: 0x07000C00 for gigabit, 0x04000800 for 100 Mb/s, 0x04000400 for 10 Mb/s.
- 0x00001000 is ORed in for full duplex.
- 0x03000000 is ORed in when both the reduced-pin flag and the transmit-delay PHY flag are set.

If no mode is common to both sides, the block falls back to 10 Mb/s half duplex.

Top module: `link_mode_resolver`

## Requirements
- R1: The word used for matching is `partner_ability_i & local_adv_i`. An ability present on only one side never selects a mode.
- R2: The mode chosen is the first of this list that matches: 1000 full, 1000 half, 100 full, 100 half, 10 full, 10 half.
- R3: The ability bits are as follows. 1000 full needs bits 0 and 5. 1000 half needs bits 0 and 6. 100 full needs bit 8, 100 half needs bit 7, 10 full needs bit 6 and 10 half needs bit 5. As a result, bit 5 or bit 6 together with bit 0 resolves to a gigabit mode.
- R4: The field value is 0x07000C00 for 1000, 0x04000800 for 100 and 0x04000400 for 10. Full duplex adds 0x00001000.
- R5: When no entry matches, the field value is 0x04000400 and the mode code is 3'b000.
- R6: Bits of `cur_ctrl_i` outside mask 0x0F001C00, as sampled in the start cycle, appear unchanged in `ctrl_value_o`.
- R7: 0x03000000 is ORed into the value only when `rgmii_en_i` and `tx_delay_phy_i` are both high in the start cycle.
- R8: An accepted start gives a `ctrl_we_o` pulse of exactly one cycle, in the cycle after start. After reset all outputs are zero.
- R9: If `rgmii_en_i` was high at an accepted start, `delay_we_o` is high for the two cycles after the control write. It carries 0x0441 and then 0x0440. Otherwise `delay_we_o` stays low. `delay_value_o` is zero whenever `delay_we_o` is low.
- R10: `mode_o` is {speed, full}, with speed 2'b00 = 10, 2'b01 = 100 and 2'b10 = 1000. It is updated with `ctrl_we_o` and holds between writes, as `ctrl_value_o` does.
- R11: A start is ignored during the control-write cycle and during the cycle that carries 0x0441. A start in the 0x0440 cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to resolve the link mode |
| partner_ability_i | input | 16 | Link partner ability word |
| local_adv_i | input | 16 | Local advertisement word |
| cur_ctrl_i | input | 32 | Current station-control value |
| rgmii_en_i | input | 1 | MAC uses the reduced-pin gigabit interface |
| tx_delay_phy_i | input | 1 | Attached PHY needs the transmit-delay setting |
| ctrl_value_o | output | 32 | New station-control value |
| ctrl_we_o | output | 1 | Write strobe for the station-control value |
| mode_o | output | 3 | Resolved {speed, full-duplex} code |
| delay_value_o | output | 16 | Clock-delay register value |
| delay_we_o | output | 1 | Write strobe for the clock-delay register |

## Verification
The hardest case to reach is a start that lands inside the busy window of a reduced-pin sequence. The window ends on a cycle boundary, so the start has to arrive in the 0x0441 cycle, where it must be dropped, or in the 0x0440 cycle, where it must be taken. The bench drives these cases with starts held high for several cycles and with random start density. A behavioural model keeps its own count of pending delay writes and is compared with the design on every clock. The gigabit/10 Mb/s bit overlap is reached on purpose with words that carry bit 0 and only one of bits 5 or 6.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2
  } speed_e;

  typedef struct packed {
    logic   hit;
    speed_e spd;
    logic   full;
  } pick_t;

  localparam int NUM_PICK    = 6;
  localparam int SEL_BIT     = 0;
  localparam int GIG_FD_BIT  = 5;
  localparam int GIG_HD_BIT  = 6;
  localparam int T10_HD_BIT  = 5;
  localparam int T10_FD_BIT  = 6;
  localparam int T100_HD_BIT = 7;
  localparam int T100_FD_BIT = 8;

  localparam logic [31:0] FIELD_MASK = 32'h0F00_1C00;
  localparam logic [31:0] BASE_1000  = 32'h0700_0C00;
  localparam logic [31:0] BASE_100   = 32'h0400_0800;
  localparam logic [31:0] BASE_10    = 32'h0400_0400;
  localparam logic [31:0] FULL_FLAG  = 32'h0000_1000;
  localparam logic [31:0] TXDLY_FLAG = 32'h0300_0000;

  localparam logic [15:0] DLY_ARM = 16'h0441;
  localparam logic [15:0] DLY_REL = 16'h0440;

  // Entry index is the rank: 0 wins over 1, and so on.
  function automatic pick_t pick_of(int idx);
    pick_t p;
    p.hit = 1'b1;
    case (idx)
      0:       begin p.spd = SPD_1000; p.full = 1'b1; end
      1:       begin p.spd = SPD_1000; p.full = 1'b0; end
      2:       begin p.spd = SPD_100;  p.full = 1'b1; end
      3:       begin p.spd = SPD_100;  p.full = 1'b0; end
      4:       begin p.spd = SPD_10;   p.full = 1'b1; end
      default: begin p.spd = SPD_10;   p.full = 1'b0; end
    endcase
    return p;
  endfunction

  function automatic logic [15:0] need_of(int idx);
    logic [15:0] m;
    m = '0;
    case (idx)
      0:       begin m[SEL_BIT] = 1'b1; m[GIG_FD_BIT] = 1'b1; end
      1:       begin m[SEL_BIT] = 1'b1; m[GIG_HD_BIT] = 1'b1; end
      2:       m[T100_FD_BIT] = 1'b1;
      3:       m[T100_HD_BIT] = 1'b1;
      4:       m[T10_FD_BIT]  = 1'b1;
      default: m[T10_HD_BIT]  = 1'b1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lmr_match.sv
module lmr_match
  import lmr_pkg::*;
#(
  parameter int ABIL_W = 16
) (
  input  logic [ABIL_W-1:0] partner_i,
  input  logic [ABIL_W-1:0] adv_i,
  output pick_t             pick_o
);

  logic [ABIL_W-1:0]   cand;
  logic [NUM_PICK-1:0] hit;

  assign cand = partner_i & adv_i;

  for (genvar g = 0; g < NUM_PICK; g++) begin : g_entry
    localparam logic [ABIL_W-1:0] NEED = ABIL_W'(need_of(g));
    assign hit[g] = (cand & NEED) == NEED;
  end

  // Scan from lowest rank upward so the highest-ranked hit is written last.
  always_comb begin
    pick_o = '{hit: 1'b0, spd: SPD_10, full: 1'b0};
    for (int i = NUM_PICK - 1; i >= 0; i--) begin
      if (hit[i]) pick_o = pick_of(i);
    end
  end

endmodule

// File: rtl/lmr_compose.sv
module lmr_compose
  import lmr_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  pick_t             pick_i,
  input  logic [CTRL_W-1:0] cur_i,
  input  logic              rgmii_i,
  input  logic              txdly_i,
  output logic [CTRL_W-1:0] value_o,
  output logic [2:0]        mode_o
);

  localparam logic [CTRL_W-1:0] KEEP = ~CTRL_W'(FIELD_MASK);

  speed_e            spd_eff;
  logic              full_eff;
  logic [CTRL_W-1:0] base;

  assign spd_eff  = pick_i.hit ? pick_i.spd : SPD_10;
  assign full_eff = pick_i.hit & pick_i.full;

  always_comb begin
    case (spd_eff)
      SPD_1000: base = CTRL_W'(BASE_1000);
      SPD_100:  base = CTRL_W'(BASE_100);
      default:  base = CTRL_W'(BASE_10);
    endcase
  end

  assign value_o = (cur_i & KEEP) | base
                 | (full_eff ? CTRL_W'(FULL_FLAG) : '0)
                 | ((rgmii_i & txdly_i) ? CTRL_W'(TXDLY_FLAG) : '0);

  assign mode_o = {spd_eff, full_eff};

endmodule

// File: rtl/lmr_delay_seq.sv
module lmr_delay_seq
  import lmr_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  output logic             we_o,
  output logic [DLY_W-1:0] value_o,
  output logic             busy_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_REL} st_e;

  st_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_o    <= 1'b0;
      value_o <= '0;
    end else begin
      case (state_q)
        ST_ARM: begin
          we_o    <= 1'b1;
          value_o <= DLY_W'(DLY_ARM);
          state_q <= ST_REL;
        end
        ST_REL: begin
          we_o    <= 1'b1;
          value_o <= DLY_W'(DLY_REL);
          state_q <= ST_IDLE;
        end
        default: begin
          we_o    <= 1'b0;
          value_o <= '0;
          if (fire_i) state_q <= ST_ARM;
        end
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;

endmodule

// File: rtl/link_mode_resolver.sv
module link_mode_resolver
  import lmr_pkg::*;
#(
  parameter int ABIL_W = 16,
  parameter int CTRL_W = 32,
  parameter int DLY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ABIL_W-1:0] partner_ability_i,
  input  logic [ABIL_W-1:0] local_adv_i,
  input  logic [CTRL_W-1:0] cur_ctrl_i,
  input  logic              rgmii_en_i,
  input  logic              tx_delay_phy_i,
  output logic [CTRL_W-1:0] ctrl_value_o,
  output logic              ctrl_we_o,
  output logic [2:0]        mode_o,
  output logic [DLY_W-1:0]  delay_value_o,
  output logic              delay_we_o
);

  pick_t             pick;
  logic [CTRL_W-1:0] next_value;
  logic [2:0]        next_mode;
  logic              seq_busy;
  logic              fire;

  lmr_match #(.ABIL_W(ABIL_W)) u_match (
    .partner_i (partner_ability_i),
    .adv_i     (local_adv_i),
    .pick_o    (pick)
  );

  lmr_compose #(.CTRL_W(CTRL_W)) u_compose (
    .pick_i  (pick),
    .cur_i   (cur_ctrl_i),
    .rgmii_i (rgmii_en_i),
    .txdly_i (tx_delay_phy_i),
    .value_o (next_value),
    .mode_o  (next_mode)
  );

  assign fire = start_i & ~ctrl_we_o & ~seq_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_value_o <= '0;
      ctrl_we_o    <= 1'b0;
      mode_o       <= '0;
    end else begin
      ctrl_we_o <= fire;
      if (fire) begin
        ctrl_value_o <= next_value;
        mode_o       <= next_mode;
      end
    end
  end

  lmr_delay_seq #(.DLY_W(DLY_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire & rgmii_en_i),
    .we_o    (delay_we_o),
    .value_o (delay_value_o),
    .busy_o  (seq_busy)
  );

endmodule

// File: rtl/lmr_checker.sv
module lmr_checker #(
  parameter int CTRL_W = 32,
  parameter int DLY_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CTRL_W-1:0] cur_ctrl_i,
  input logic              rgmii_en_i,
  input logic              tx_delay_phy_i,
  input logic [CTRL_W-1:0] ctrl_value_o,
  input logic              ctrl_we_o,
  input logic [2:0]        mode_o,
  input logic [DLY_W-1:0]  delay_value_o,
  input logic              delay_we_o
);

  localparam logic [CTRL_W-1:0] KEEP = ~CTRL_W'(32'h0F00_1C00);
  localparam logic [DLY_W-1:0]  ARM  = DLY_W'(16'h0441);
  localparam logic [DLY_W-1:0]  REL  = DLY_W'(16'h0440);

  AST_ONE_CYCLE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |=> !ctrl_we_o); // R8

  AST_KEEP_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |-> ((ctrl_value_o & KEEP) == ($past(cur_ctrl_i) & KEEP))); // R6

  AST_TXDLY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_o && $past(rgmii_en_i && tx_delay_phy_i)) |-> (ctrl_value_o[25:24] == 2'b11)); // R7

  AST_DLY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_o && $past(rgmii_en_i)) |=> (delay_we_o && delay_value_o == ARM)); // R9

  AST_DLY_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delay_we_o && delay_value_o == ARM) |=> (delay_we_o && delay_value_o == REL)); // R9

  AST_NO_DLY_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_o && !$past(rgmii_en_i)) |=> !delay_we_o); // R9

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we_o && delay_we_o)); // R9

  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !ctrl_we_o && !(delay_we_o && delay_value_o == ARM)) |=> ctrl_we_o); // R11

  AST_MODE_DUPLEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |-> (mode_o[0] == ctrl_value_o[12])); // R10

endmodule

bind link_mode_resolver lmr_checker u_chk (.*);

// File: tb/tb_link_mode_resolver.sv
module tb_link_mode_resolver;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] partner_ability_i = '0;
  logic [15:0] local_adv_i = '0;
  logic [31:0] cur_ctrl_i = '0;
  logic        rgmii_en_i = 1'b0;
  logic        tx_delay_phy_i = 1'b0;
  logic [31:0] ctrl_value_o;
  logic        ctrl_we_o;
  logic [2:0]  mode_o;
  logic [15:0] delay_value_o;
  logic        delay_we_o;

  always #2.5 clk_i = ~clk_i;

  link_mode_resolver dut (.*);

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R8 reset";

  // reference model state
  logic [31:0] m_val = '0;
  logic        m_we = 0;
  logic [2:0]  m_mode = '0;
  logic [15:0] m_dval = '0;
  logic        m_dwe = 0;
  int          m_pend = 0;

  function automatic int rank_of(logic [15:0] c);
    if (c[0] && c[5]) return 0;
    if (c[0] && c[6]) return 1;
    if (c[8]) return 2;
    if (c[7]) return 3;
    if (c[6]) return 4;
    if (c[5]) return 5;
    return 6;
  endfunction

  function automatic logic [31:0] field_of(int r);
    logic [31:0] v;
    if (r <= 1) v = 32'h0700_0C00;
    else if (r <= 3) v = 32'h0400_0800;
    else v = 32'h0400_0400;
    if (r == 0 || r == 2 || r == 4) v = v | 32'h0000_1000;
    return v;
  endfunction

  function automatic logic [2:0] code_of(int r);
    logic [1:0] s;
    s = (r <= 1) ? 2'd2 : (r <= 3) ? 2'd1 : 2'd0;
    return {s, (r == 0 || r == 2 || r == 4)};
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_val <= '0; m_we <= 0; m_mode <= '0; m_dval <= '0; m_dwe <= 0; m_pend <= 0;
    end else begin
      int r;
      bit take;
      take = start_i && !m_we && m_pend == 0;
      if (m_pend == 2) begin
        m_dwe <= 1; m_dval <= 16'h0441; m_pend <= 1;
      end else if (m_pend == 1) begin
        m_dwe <= 1; m_dval <= 16'h0440; m_pend <= 0;
      end else begin
        m_dwe <= 0; m_dval <= '0;
        if (take && rgmii_en_i) m_pend <= 2;
      end
      m_we <= take;
      if (take) begin
        r = rank_of(partner_ability_i & local_adv_i);
        m_val <= (cur_ctrl_i & ~32'h0F00_1C00) | field_of(r)
               | ((rgmii_en_i && tx_delay_phy_i) ? 32'h0300_0000 : 32'h0);
        m_mode <= code_of(r);
      end
    end
  end

  task automatic cmp(string fld, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, fld, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk_i) begin
    if (!done) begin
      cmp("ctrl_value", ctrl_value_o, m_val);
      cmp("ctrl_we", {31'd0, ctrl_we_o}, {31'd0, m_we});
      cmp("mode", {29'd0, mode_o}, {29'd0, m_mode});
      cmp("delay_value", {16'd0, delay_value_o}, {16'd0, m_dval});
      cmp("delay_we", {31'd0, delay_we_o}, {31'd0, m_dwe});
    end
  end

  task automatic go(string req, logic [15:0] p, logic [15:0] a, logic [31:0] c,
                    logic rg, logic td, int hold);
    @(negedge clk_i);
    cur_req = req;
    partner_ability_i = p; local_adv_i = a; cur_ctrl_i = c;
    rgmii_en_i = rg; tx_delay_phy_i = td; start_i = 1'b1;
    repeat (hold) @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);       // R8: reset state compared each cycle
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: partner offers 100 full, advertisement only 100 half
    go("R1", 16'h0180, 16'h0080, 32'h0, 0, 0, 1);
    go("R1 adv_only", 16'h0000, 16'h01E1, 32'h0, 0, 0, 1);
    // R2: priority among common abilities
    go("R2 100f", 16'h01E0, 16'hFFFF, 32'h0, 0, 0, 1);
    go("R2 100h", 16'h00C0, 16'hFFFF, 32'h0, 0, 0, 1);
    go("R2 10f", 16'h0060, 16'hFFFF, 32'h0, 0, 0, 1);
    // R3: selector plus bit 5/6 is gigabit; bit 5 alone is 10 half
    go("R3 1000f", 16'h0021, 16'hFFFF, 32'h0, 0, 0, 1);
    go("R3 1000h", 16'h0041, 16'hFFFF, 32'h0, 0, 0, 1);
    go("R3 10h", 16'h0020, 16'hFFFF, 32'h0, 0, 0, 1);
    // R4: field values per speed and duplex
    go("R4", 16'h0101, 16'h0101, 32'h0, 0, 0, 1);
    // R5: nothing common -> default
    go("R5", 16'h0001, 16'hFFFF, 32'h0, 0, 0, 1);
    go("R5 zero", 16'h0000, 16'h0000, 32'hFFFF_FFFF, 0, 0, 1);
    // R6: unrelated bits preserved
    go("R6", 16'h0021, 16'hFFFF, 32'hFFFF_FFFF, 0, 0, 1);
    go("R6 mix", 16'h0080, 16'hFFFF, 32'hA5A5_5A5A, 0, 0, 1);
    // R7: transmit delay only with both flags
    go("R7 both", 16'h0100, 16'hFFFF, 32'h0, 1, 1, 1);
    go("R7 txd_only", 16'h0100, 16'hFFFF, 32'h0, 0, 1, 1);
    // R9: delay pulse pair
    go("R9", 16'h0041, 16'hFFFF, 32'h1234_5678, 1, 0, 1);
    // R10: mode code holds between writes
    go("R10", 16'h0080, 16'hFFFF, 32'h0, 0, 0, 1);
    repeat (5) @(negedge clk_i);
    // R11: start held through busy window
    go("R11 plain", 16'h0100, 16'hFFFF, 32'h0, 0, 0, 5);
    go("R11 rgmii", 16'h0021, 16'hFFFF, 32'h0, 1, 1, 7);
    // R8 and all: random traffic
    cur_req = "R8 random";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      start_i = ($urandom_range(0, 2) == 0);
      partner_ability_i = 16'($urandom) & (($urandom_range(0, 1) == 0) ? 16'h01E1 : 16'hFFFF);
      local_adv_i = 16'($urandom) | 16'($urandom);
      cur_ctrl_i = $urandom;
      rgmii_en_i = $urandom_range(0, 1) == 1;
      tx_delay_phy_i = $urandom_range(0, 1) == 1;
    end
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (6) @(negedge clk_i);
    finish_run();
  end

endmodule